// File: doc/BRIEF.md
# E1 Automatic Loopback Switching Controller

This block decides whether one E1 line channel runs with its local loop or its remote loop closed. A loop can be requested statically by a configuration bit, or it can be closed and opened automatically when an in-band loop code is recognised. A separate code detector, not part of this block, reports each recognised code as a one-cycle pulse. There are four kinds of pulse: activate or deactivate, seen on the system side or on the line side.

Codes seen on the system side drive the automatic local loop. Codes seen on the line side drive the automatic remote loop. Each direction of automatic switching has its own enable. The loop that reaches the channel is the automatic state ORed with the static request. A 4-bit status field records the kind of code detected most recently, whether or not switching was enabled. Enabling both directions at once is not a legal configuration. The block answers it with an error flag and keeps both automatic loops open.

Top module: `e1LoopCtrl`

## Requirements
- R1: With only `sysSwEn` set, a `sysActPulse` makes `localLoop` high from the cycle after the pulse.
- R2: With only `sysSwEn` set, a `sysDeactPulse` clears the automatic local loop from the cycle after the pulse. With only `lineSwEn` set, `lineActPulse` and `lineDeactPulse` set and clear the automatic remote loop (`remoteLoop`) in the same way.
- R3: `localLoop` is the OR of the automatic local state and `staticLocal`. `remoteLoop` is the OR of the automatic remote state and `staticRemote`. A static bit therefore keeps its loop closed through an automatic deactivation.
- R4: A pulse that arrives while its enable is low has no effect on the loops, and setting the enable afterwards causes no switching.
- R5: Clearing `sysSwEn` drops an automatically closed local loop in the same cycle, combinationally. Clearing `lineSwEn` does the same for the remote loop. The released loop stays open when the enable is set again.
- R6: `codeStatus` uses one bit per code kind: bit 3 system activate, bit 2 system deactivate, bit 1 line activate, bit 0 line deactivate. In any cycle with at least one pulse it loads the OR of that cycle's pulses, visible from the next cycle. Otherwise it holds. It does not depend on the enables.
- R7: While `sysSwEn` and `lineSwEn` are both high, `cfgError` is high, both automatic states are cleared, and the loops equal the static bits. `cfgError` is low otherwise.
- R8: An activate and a deactivate pulse for the same side in one cycle leave that automatic loop open.
- R9: Synchronous active-high `rst` clears both automatic states and `codeStatus` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sysSwEn | input | 1 | Enable switching by system-side codes |
| lineSwEn | input | 1 | Enable switching by line-side codes |
| staticLocal | input | 1 | Static local-loop request |
| staticRemote | input | 1 | Static remote-loop request |
| sysActPulse | input | 1 | System-side activate code detected |
| sysDeactPulse | input | 1 | System-side deactivate code detected |
| lineActPulse | input | 1 | Line-side activate code detected |
| lineDeactPulse | input | 1 | Line-side deactivate code detected |
| localLoop | output | 1 | Effective local-loop control |
| remoteLoop | output | 1 | Effective remote-loop control |
| codeStatus | output | 4 | Most recent detected code kind(s) |
| cfgError | output | 1 | Both enables set |

## Verification
The hardest case to reach is an automatic loop that is dropped without a deactivate code, either because its enable falls or because the other enable rises. It must then stay open once the configuration becomes legal again. The bench first closes a loop with a code. It then changes the enables at a falling clock edge and checks the loop a moment later, before any rising edge, so that the drop is shown to be combinational. After that it waits several cycles with the enable restored and checks again, which shows that the stored state was cleared and not merely masked.

// File: rtl/e1LoopPkg.sv
package e1LoopPkg;
  localparam int CODE_W = 4;
  localparam int BIT_SYS_ACT    = 3;
  localparam int BIT_SYS_DEACT  = 2;
  localparam int BIT_LINE_ACT   = 1;
  localparam int BIT_LINE_DEACT = 0;

  typedef struct packed {
    logic setLocal;
    logic clrLocal;
    logic setRemote;
    logic clrRemote;
    logic localGate;
    logic remoteGate;
    logic loadStatus;
    logic [CODE_W-1:0] statusNext;
  } loopStrobes_t;
endpackage

// File: rtl/e1LoopControl.sv
module e1LoopControl
  import e1LoopPkg::*;
(
  input  logic sysSwEn,
  input  logic lineSwEn,
  input  logic sysActPulse,
  input  logic sysDeactPulse,
  input  logic lineActPulse,
  input  logic lineDeactPulse,
  output loopStrobes_t strobes,
  output logic cfgError
);
  logic bothEn;
  logic sysOk;
  logic lineOk;
  logic [CODE_W-1:0] pulseVec;

  always_comb begin
    bothEn = sysSwEn & lineSwEn;
    sysOk  = sysSwEn & ~lineSwEn;
    lineOk = lineSwEn & ~sysSwEn;

    pulseVec = '0;
    pulseVec[BIT_SYS_ACT]    = sysActPulse;
    pulseVec[BIT_SYS_DEACT]  = sysDeactPulse;
    pulseVec[BIT_LINE_ACT]   = lineActPulse;
    pulseVec[BIT_LINE_DEACT] = lineDeactPulse;

    // a deactivate in the same cycle wins over an activate
    strobes.setLocal   = sysOk & sysActPulse & ~sysDeactPulse;
    strobes.clrLocal   = ~sysOk | sysDeactPulse;
    strobes.setRemote  = lineOk & lineActPulse & ~lineDeactPulse;
    strobes.clrRemote  = ~lineOk | lineDeactPulse;
    strobes.localGate  = sysOk;
    strobes.remoteGate = lineOk;
    strobes.loadStatus = |pulseVec;
    strobes.statusNext = pulseVec;

    cfgError = bothEn;
  end
endmodule

// File: rtl/e1LoopDatapath.sv
module e1LoopDatapath
  import e1LoopPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  loopStrobes_t strobes,
  input  logic staticLocal,
  input  logic staticRemote,
  output logic localLoop,
  output logic remoteLoop,
  output logic [CODE_W-1:0] codeStatus
);
  logic autoLocal;
  logic autoRemote;
  logic [CODE_W-1:0] statusReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      autoLocal  <= 1'b0;
      autoRemote <= 1'b0;
      statusReg  <= '0;
    end else begin
      if (strobes.clrLocal)       autoLocal <= 1'b0;
      else if (strobes.setLocal)  autoLocal <= 1'b1;
      if (strobes.clrRemote)      autoRemote <= 1'b0;
      else if (strobes.setRemote) autoRemote <= 1'b1;
      if (strobes.loadStatus)     statusReg <= strobes.statusNext;
    end
  end

  always_comb begin
    localLoop  = (autoLocal & strobes.localGate) | staticLocal;
    remoteLoop = (autoRemote & strobes.remoteGate) | staticRemote;
    codeStatus = statusReg;
  end
endmodule

// File: rtl/e1LoopCtrl.sv
module e1LoopCtrl
  import e1LoopPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sysSwEn,
  input  logic lineSwEn,
  input  logic staticLocal,
  input  logic staticRemote,
  input  logic sysActPulse,
  input  logic sysDeactPulse,
  input  logic lineActPulse,
  input  logic lineDeactPulse,
  output logic localLoop,
  output logic remoteLoop,
  output logic [3:0] codeStatus,
  output logic cfgError
);
  loopStrobes_t strobes;

  e1LoopControl uCtrl (
    .sysSwEn(sysSwEn), .lineSwEn(lineSwEn),
    .sysActPulse(sysActPulse), .sysDeactPulse(sysDeactPulse),
    .lineActPulse(lineActPulse), .lineDeactPulse(lineDeactPulse),
    .strobes(strobes), .cfgError(cfgError)
  );

  e1LoopDatapath uData (
    .clk(clk), .rst(rst), .strobes(strobes),
    .staticLocal(staticLocal), .staticRemote(staticRemote),
    .localLoop(localLoop), .remoteLoop(remoteLoop),
    .codeStatus(codeStatus)
  );
endmodule

// File: rtl/e1LoopCtrlChecker.sv
module e1LoopCtrlChecker (
  input logic clk,
  input logic rst,
  input logic sysSwEn,
  input logic lineSwEn,
  input logic staticLocal,
  input logic staticRemote,
  input logic sysActPulse,
  input logic sysDeactPulse,
  input logic lineActPulse,
  input logic lineDeactPulse,
  input logic localLoop,
  input logic remoteLoop,
  input logic [3:0] codeStatus,
  input logic cfgError
);
  a_r1_sys_act_closes: assert property (@(posedge clk) disable iff (rst)
    (sysSwEn && !lineSwEn && sysActPulse && !sysDeactPulse)
      |=> (localLoop || !(sysSwEn && !lineSwEn)));

  a_r2_line_deact_opens: assert property (@(posedge clk) disable iff (rst)
    lineDeactPulse |=> (remoteLoop == staticRemote || lineActPulse));

  a_r3_static_or: assert property (@(posedge clk) disable iff (rst)
    (staticLocal |-> localLoop) and (staticRemote |-> remoteLoop));

  a_r5_disable_releases: assert property (@(posedge clk) disable iff (rst)
    (!sysSwEn |-> localLoop == staticLocal) and (!lineSwEn |-> remoteLoop == staticRemote));

  a_r6_status_load: assert property (@(posedge clk) disable iff (rst)
    (sysActPulse || sysDeactPulse || lineActPulse || lineDeactPulse)
      |=> codeStatus == {$past(sysActPulse), $past(sysDeactPulse),
                         $past(lineActPulse), $past(lineDeactPulse)});

  a_r6_status_hold: assert property (@(posedge clk) disable iff (rst)
    !(sysActPulse || sysDeactPulse || lineActPulse || lineDeactPulse)
      |=> $stable(codeStatus));

  a_r7_both_enabled: assert property (@(posedge clk) disable iff (rst)
    (sysSwEn && lineSwEn) |-> (cfgError && localLoop == staticLocal
                               && remoteLoop == staticRemote));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (codeStatus == 4'b0000 && localLoop == staticLocal
             && remoteLoop == staticRemote));
endmodule

bind e1LoopCtrl e1LoopCtrlChecker uChk (.*);

// File: tb/tb_e1LoopCtrl.sv
module tb_e1LoopCtrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, sysSwEn, lineSwEn, staticLocal, staticRemote;
  logic sysActPulse, sysDeactPulse, lineActPulse, lineDeactPulse;
  logic localLoop, remoteLoop, cfgError;
  logic [3:0] codeStatus;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1LoopCtrl dut (.*);

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive pulses at a falling edge; return at the falling edge after the capture
  task automatic pulse(logic sa, logic sd, logic la, logic ld);
    @(negedge clk);
    sysActPulse = sa; sysDeactPulse = sd; lineActPulse = la; lineDeactPulse = ld;
    @(negedge clk);
    sysActPulse = 0; sysDeactPulse = 0; lineActPulse = 0; lineDeactPulse = 0;
  endtask

  task automatic setEn(logic s, logic l);
    @(negedge clk);
    sysSwEn = s; lineSwEn = l;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic tReset();
    doReset();
    chk("R9 reset local", {3'b0, localLoop}, 4'b0);
    chk("R9 reset remote", {3'b0, remoteLoop}, 4'b0);
    chk("R9 reset status", codeStatus, 4'b0000);
    chk("R7 reset cfgError", {3'b0, cfgError}, 4'b0);
  endtask

  task automatic tSysActDeact();
    setEn(1, 0);
    pulse(1, 0, 0, 0);
    chk("R1 local closed", {3'b0, localLoop}, 4'b1);
    chk("R1 remote untouched", {3'b0, remoteLoop}, 4'b0);
    chk("R6 sys act status", codeStatus, 4'b1000);
    pulse(0, 1, 0, 0);
    chk("R2 local opened", {3'b0, localLoop}, 4'b0);
    chk("R6 sys deact status", codeStatus, 4'b0100);
  endtask

  task automatic tLineActDeact();
    setEn(0, 1);
    pulse(0, 0, 1, 0);
    chk("R2 remote closed", {3'b0, remoteLoop}, 4'b1);
    chk("R2 local untouched", {3'b0, localLoop}, 4'b0);
    pulse(0, 0, 0, 1);
    chk("R2 remote opened", {3'b0, remoteLoop}, 4'b0);
    chk("R6 line deact status", codeStatus, 4'b0001);
  endtask

  task automatic tStaticOr();
    setEn(1, 0);
    staticLocal = 1;
    pulse(1, 0, 0, 0);
    pulse(0, 1, 0, 0);
    chk("R3 static local holds", {3'b0, localLoop}, 4'b1);
    staticLocal = 0;
    #1 chk("R3 local after static off", {3'b0, localLoop}, 4'b0);
    setEn(0, 0);
    staticRemote = 1;
    #1 chk("R3 static remote", {3'b0, remoteLoop}, 4'b1);
    staticRemote = 0;
  endtask

  task automatic tIgnoredWhileDisabled();
    setEn(0, 0);
    pulse(1, 0, 1, 0);
    chk("R4 local ignored", {3'b0, localLoop}, 4'b0);
    chk("R4 remote ignored", {3'b0, remoteLoop}, 4'b0);
    chk("R6 status while disabled", codeStatus, 4'b1010);
    setEn(1, 0);
    repeat (3) @(negedge clk);
    chk("R4 no late local switch", {3'b0, localLoop}, 4'b0);
    setEn(0, 1);
    repeat (3) @(negedge clk);
    chk("R4 no late remote switch", {3'b0, remoteLoop}, 4'b0);
  endtask

  task automatic tDisableReleases();
    setEn(1, 0);
    pulse(1, 0, 0, 0);
    chk("R5 local set first", {3'b0, localLoop}, 4'b1);
    sysSwEn = 0;
    #1 chk("R5 local released at once", {3'b0, localLoop}, 4'b0);
    setEn(1, 0);
    repeat (3) @(negedge clk);
    chk("R5 local stays released", {3'b0, localLoop}, 4'b0);
    setEn(0, 1);
    pulse(0, 0, 1, 0);
    lineSwEn = 0;
    #1 chk("R5 remote released at once", {3'b0, remoteLoop}, 4'b0);
    setEn(0, 1);
    repeat (3) @(negedge clk);
    chk("R5 remote stays released", {3'b0, remoteLoop}, 4'b0);
  endtask

  task automatic tBothEnabled();
    setEn(0, 1);
    pulse(0, 0, 1, 0);
    chk("R7 remote set first", {3'b0, remoteLoop}, 4'b1);
    sysSwEn = 1;
    #1 chk("R7 cfgError", {3'b0, cfgError}, 4'b1);
    chk("R7 remote forced open", {3'b0, remoteLoop}, 4'b0);
    pulse(1, 0, 1, 0);
    chk("R7 local stays open", {3'b0, localLoop}, 4'b0);
    setEn(0, 1);
    #1 chk("R7 cfgError cleared", {3'b0, cfgError}, 4'b0);
    repeat (2) @(negedge clk);
    chk("R7 remote state was cleared", {3'b0, remoteLoop}, 4'b0);
  endtask

  task automatic tSameCycle();
    setEn(1, 0);
    pulse(1, 1, 0, 0);
    chk("R8 deact wins local", {3'b0, localLoop}, 4'b0);
    chk("R6 both sys status", codeStatus, 4'b1100);
    setEn(0, 1);
    pulse(0, 0, 1, 1);
    chk("R8 deact wins remote", {3'b0, remoteLoop}, 4'b0);
    repeat (2) @(negedge clk);
    chk("R6 status held", codeStatus, 4'b0011);
  endtask

  task automatic tResetMidRun();
    setEn(1, 0);
    pulse(1, 0, 0, 0);
    doReset();
    chk("R9 reset clears local", {3'b0, localLoop}, 4'b0);
    chk("R9 reset clears status", codeStatus, 4'b0000);
  endtask

  initial begin
    rst = 1; sysSwEn = 0; lineSwEn = 0; staticLocal = 0; staticRemote = 0;
    sysActPulse = 0; sysDeactPulse = 0; lineActPulse = 0; lineDeactPulse = 0;
    tReset();
    tSysActDeact();
    tLineActDeact();
    tStaticOr();
    tIgnoredWhileDisabled();
    tDisableReleases();
    tBothEnabled();
    tSameCycle();
    tResetMidRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule